// File: doc/BRIEF.md
# Supply Fault Event Latch Register

This block holds a byte-wide record of supply and chip health faults. Four single-bit fault levels (oscillator failure, negative-rail undervoltage, positive-rail undervoltage and over-temperature) are sampled on every clock. Each one sets its own sticky bit in the event byte. Once set, a bit stays set until software clears it. The byte is reduced to one supply-fault summary bit, which feeds a higher-level interrupt register. A configuration input can leave the oscillator bit out of that reduction.

Software reads the byte through a simple address and read-strobe port. Two addresses return the same byte. A read at the peek address leaves the byte unchanged. A read at the clearing address returns the byte and then clears every event bit at the next clock edge. If a fault is present in the cycle of a clearing read, its bit stays set, because a set always wins over a clear. Read data is combinational, so the value returned is always the one from before the clear.

Top module: `sfe_event_latch`

## Requirements
- R1: Each fault input sets its own event bit on the clock edge at which it is sampled high. Oscillator failure uses bit 1, negative-rail undervoltage bit 4, positive-rail undervoltage bit 5 and over-temperature bit 7.
- R2: An event bit that has been set stays set after its fault input returns low, until a clearing read or a reset.
- R3: A strobed read at address 0x0A returns the event byte and changes none of its bits.
- R4: A strobed read at address 0x0B returns the same byte that 0x0A would return. At the next clock edge it clears all event bits, and the cleared value is seen at both addresses.
- R5: A fault input that is high in the same cycle as a clearing read leaves its bit set after that edge.
- R6: The supply-fault output is high whenever any of bits 1, 4, 5 or 7 of the event byte is set. It follows the latched bits with no extra delay.
- R7: While the oscillator mask input is high, bit 1 does not contribute to the supply-fault output. The bit itself still latches and can still be read.
- R8: Bit positions 0, 2, 3 and 6 of the read data are always zero.
- R9: A synchronous active-high reset clears all event bits at the next clock edge.
- R10: Read data is zero when the read strobe is low or the address is neither 0x0A nor 0x0B. Such cycles never clear any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_fail_i | input | 1 | Oscillator failure level |
| vneg_uv_i | input | 1 | Negative-rail undervoltage level |
| vpos_uv_i | input | 1 | Positive-rail undervoltage level |
| overtemp_i | input | 1 | Over-temperature level |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| osc_mask_i | input | 1 | Leaves the oscillator bit out of the summary when high |
| rd_data_o | output | 8 | Read data (combinational) |
| supply_fault_o | output | 1 | Summary of the latched event bits |

## Verification
The assertions check on every cycle the rules that apply to each bit: a set bit holds unless it is cleared, a fault beats a clear, a clear with no fault empties the bit, reset empties it, and the reserved read positions stay zero. The masking rule for the summary is checked on every cycle as well. Some behaviour only the bench scenarios can show: that each fault lands in its documented bit, that the two addresses return the same byte, and that only one of them clears it. They also show that reads with the strobe low or at other addresses return zero and leave the byte intact.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  parameter int unsigned DATA_W  = 8;
  parameter int unsigned ADDR_W  = 8;
  parameter int unsigned NUM_EVT = 4;

  // index 0 osc, 1 vneg, 2 vpos, 3 overtemp
  localparam int unsigned EVT_POS [NUM_EVT] = '{1, 4, 5, 7};
  localparam int unsigned OSC_IDX = 0;

  localparam logic [ADDR_W-1:0] PEEK_ADDR  = ADDR_W'(8'h0A);
  localparam logic [ADDR_W-1:0] CLEAR_ADDR = ADDR_W'(8'h0B);

  function automatic logic [DATA_W-1:0] used_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[EVT_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/sfe_sticky_bit.sv
module sfe_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= set_i | (q_o & ~clr_i);
  end

  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !q_o);
endmodule

// File: rtl/sfe_read_port.sv
module sfe_read_port
  import sfe_pkg::*;
(
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] evt_byte_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clear_o
);
  logic hit_peek, hit_clear;

  always_comb begin
    hit_peek  = rd_en_i && (rd_addr_i == PEEK_ADDR);
    hit_clear = rd_en_i && (rd_addr_i == CLEAR_ADDR);
    clear_o   = hit_clear;
    rd_data_o = (hit_peek || hit_clear) ? evt_byte_i : '0;
  end
endmodule

// File: rtl/sfe_summary.sv
module sfe_summary
  import sfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_q_i,
  input  logic               osc_mask_i,
  output logic               fault_o
);
  logic [NUM_EVT-1:0] gate;

  always_comb begin
    gate          = '1;
    gate[OSC_IDX] = ~osc_mask_i;
    fault_o       = |(evt_q_i & gate);
  end

  a_r7_mask_osc: assert property (@(posedge clk) disable iff (rst)
    (osc_mask_i && ((evt_q_i & ~(NUM_EVT'(1) << OSC_IDX)) == '0)) |-> !fault_o);
  a_r6_any_unmasked: assert property (@(posedge clk) disable iff (rst)
    ((evt_q_i & ~(NUM_EVT'(1) << OSC_IDX)) != '0) |-> fault_o);
endmodule

// File: rtl/sfe_event_latch.sv
module sfe_event_latch
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_fail_i,
  input  logic              vneg_uv_i,
  input  logic              vpos_uv_i,
  input  logic              overtemp_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              osc_mask_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              supply_fault_o
);
  localparam logic [DATA_W-1:0] USED_MASK = used_bits();

  logic [NUM_EVT-1:0] fault_raw;
  logic [NUM_EVT-1:0] evt_q;
  logic [DATA_W-1:0]  evt_byte;
  logic               clear;

  assign fault_raw = {overtemp_i, vpos_uv_i, vneg_uv_i, osc_fail_i};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    sfe_sticky_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .set_i (fault_raw[i]),
      .clr_i (clear),
      .q_o   (evt_q[i])
    );
  end

  always_comb begin
    evt_byte = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_byte[EVT_POS[i]] = evt_q[i];
  end

  sfe_read_port u_rd (
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .evt_byte_i (evt_byte),
    .rd_data_o  (rd_data_o),
    .clear_o    (clear)
  );

  sfe_summary u_sum (
    .clk        (clk),
    .rst        (rst),
    .evt_q_i    (evt_q),
    .osc_mask_i (osc_mask_i),
    .fault_o    (supply_fault_o)
  );

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o & ~USED_MASK) == '0);
  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |-> (rd_data_o == '0));
endmodule

// File: tb/sfe_event_latch_tb_top.sv
module sfe_event_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc = 1'b0, vneg = 1'b0, vpos = 1'b0, hot = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       mask = 1'b0;
  logic [7:0] rdata;
  logic       sf;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sfe_event_latch dut_i (
    .clk(clk), .rst(rst), .osc_fail_i(osc), .vneg_uv_i(vneg),
    .vpos_uv_i(vpos), .overtemp_i(hot), .rd_en_i(rd_en),
    .rd_addr_i(addr), .osc_mask_i(mask), .rd_data_o(rdata),
    .supply_fault_o(sf)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // strobed read; returns data seen before the edge, then commits the edge
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata;
    step(); rd_en = 1'b0; addr = 8'h00;
  endtask

  task automatic peek(output logic [7:0] d);
    rd_en = 1'b1; addr = 8'h0A; #1; d = rdata;
    rd_en = 1'b0; addr = 8'h00;
  endtask

  task automatic pulse(input int which);
    case (which) 0: osc = 1; 1: vneg = 1; 2: vpos = 1; default: hot = 1; endcase
    step();
    osc = 0; vneg = 0; vpos = 0; hot = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(d); check("R9 reset state", d, 8'h00);
    check("R9 reset summary", {7'd0, sf}, 8'h00);
  endtask

  task automatic t_each_bit();
    logic [7:0] d;
    logic [7:0] pos [4] = '{8'h02, 8'h10, 8'h20, 8'h80};
    for (int k = 0; k < 4; k++) begin
      pulse(k); step();
      peek(d); check("R1 bit position", d, pos[k]);
      check("R6 summary", {7'd0, sf}, 8'h01);
      rd(8'h0A, d); check("R3 peek data", d, pos[k]);
      peek(d); check("R2/R3 still set", d, pos[k]);
      rd(8'h0B, d); check("R4 clear-read data", d, pos[k]);
      peek(d); check("R4 cleared", d, 8'h00);
      check("R4 summary low", {7'd0, sf}, 8'h00);
    end
  endtask

  task automatic t_all_reserved();
    logic [7:0] d;
    osc = 1; vneg = 1; vpos = 1; hot = 1; step();
    osc = 0; vneg = 0; vpos = 0; hot = 0;
    peek(d); check("R8 all set", d, 8'hB2);
    check("R8 reserved zero", d & 8'h4D, 8'h00);
    rd(8'h0B, d); check("R4 clear all data", d, 8'hB2);
    peek(d); check("R4 all cleared", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    mask = 1; pulse(0); #1;
    check("R7 masked osc summary", {7'd0, sf}, 8'h00);
    peek(d); check("R7 osc still latched", d, 8'h02);
    mask = 0; #1;
    check("R6 unmasked osc summary", {7'd0, sf}, 8'h01);
    mask = 1; pulse(1); #1;
    check("R7 mask keeps vneg", {7'd0, sf}, 8'h01);
    mask = 0;
    rd(8'h0B, d); check("R4 clear after mask", d, 8'h12);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse(0);
    vneg = 1; osc = 1;
    rd(8'h0B, d); check("R5 data before clear", d, 8'h02);
    vneg = 0; osc = 0;
    peek(d); check("R5 set beats clear", d, 8'h12);
    rd(8'h0B, d); peek(d); check("R5 then clears", d, 8'h00);
  endtask

  task automatic t_idle_reads();
    logic [7:0] d;
    pulse(3);
    rd_en = 0; addr = 8'h0B; #1; check("R10 strobe low data", rdata, 8'h00);
    step(); addr = 8'h00;
    rd(8'h0C, d); check("R10 other address data", d, 8'h00);
    rd(8'h09, d); check("R10 other address data 2", d, 8'h00);
    peek(d); check("R10 no clear", d, 8'h80);
  endtask

  task automatic t_mid_reset();
    logic [7:0] d;
    pulse(2);
    rst = 1; step(); rst = 0;
    peek(d); check("R9 mid reset clears", d, 8'h00);
  endtask

  initial begin
    @(negedge clk); step(); step(); rst = 0;
    t_reset();
    t_each_bit();
    t_all_reserved();
    t_mask();
    t_set_wins();
    t_idle_reads();
    t_mid_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule